// File: doc/BRIEF.md
# Aging Priority Multi-Port Channel Arbiter

This block sits between a set of request ports and four memory-channel back ends. Each request port delivers transactions that already cover exactly one interleave block. The transactions go into a small per-port FIFO. Every cycle, the head of each port FIFO names one channel through two address bits that sit just above the block offset. A separate arbiter for each channel picks one of the ports that want it, and a crossbar moves the winning head into that channel's back-end queue. Ports that target different channels move in the same cycle.

Each port is strapped to a high or a low priority level. A low-priority head that keeps losing builds up age, one count per cycle. When the age reaches a threshold, the head becomes "aged" and ranks above every other request on its channel, so a low-priority port cannot starve behind a steady stream of high-priority traffic. Inside each rank (aged, high, low), a per-channel round-robin pointer breaks ties. A channel whose queue is full grants nobody. Its port heads wait, while the other channels keep flowing.

Top module: `aging_xbar_arb`

## Requirements
- R1: The target channel of a transaction is address bits [BOFF+1:BOFF], where BOFF = log2(BLK_BYTES). With the default 64-byte block these are bits [7:6]. No other address bit affects routing. The transaction leaves on that channel's output with its address and data unchanged, and out_src gives the number of the port it came from.
- R2: An input beat is accepted on a cycle with in_valid and in_ready both high. in_ready drops while the port FIFO is full. Each channel output holds valid, address, data and source stable while out_valid is high and out_ready is low. The transactions of one port leave a channel in the order they were accepted.
- R3: Ports whose heads target different channels are granted in the same cycle. A beat accepted on clock edge N appears on out_valid after edge N+1 when its channel queue has room and it faces no competition.
- R4: On a channel, a high-priority head that is not aged wins over any low-priority head that is not aged.
- R5: A low-priority head gains one count of age for each cycle it is valid and not granted. Its age returns to zero when it is granted. A head that has been passed over AGE_MAX times (default 6) wins the next grant on its channel ahead of all high-priority heads. The next head of that port starts again at age zero.
- R6: Among heads of equal rank on one channel, grants rotate round-robin, so that with N such heads always requesting, any N consecutive grants serve each of them once.
- R7: A channel grants at most one port per cycle, and none while its back-end queue is full. A stalled channel does not hold up transactions that other ports send to other channels.
- R8: After reset every out_valid is low and every in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_hi | input | NPORT | Priority strap per port, 1 = high level |
| in_valid | input | NPORT | Request beat valid, one bit per port |
| in_ready | output | NPORT | Port FIFO can take a beat |
| in_addr | input | NPORT*AW | Byte address per port, port p at bits [p*AW +: AW] |
| in_data | input | NPORT*DW | Payload per port, port p at bits [p*DW +: DW] |
| out_valid | output | 4 | Channel queue holds a transaction |
| out_ready | input | 4 | Channel back end takes the head this cycle |
| out_addr | output | 4*AW | Address at each channel queue head |
| out_data | output | 4*DW | Payload at each channel queue head |
| out_src | output | 4*log2(NPORT) | Originating port of each channel queue head |

## Verification
The hardest case to reach is aging under sustained contention. A low-priority head is promoted only when two high-priority ports keep its channel busy on every cycle for the whole threshold window. The stimulus holds both high ports' in_valid high for the whole window, so their FIFOs never run dry. It then checks that the low port's first transaction is exactly output number AGE_MAX+1 on that channel and its second is number 2*AGE_MAX+2, which shows the age resetting on grant. A second hard case is a full back-end queue. Holding out_ready low on one channel fills both that channel's queue and the port FIFO behind it. The test counts the accepted beats, checks that a different port still reaches another channel during the stall, and then checks the drain order.

// File: rtl/aging_arb_pkg.sv
package aging_arb_pkg;
  localparam int NCHAN = 4;
  localparam int CHW   = $clog2(NCHAN);
  typedef logic [CHW-1:0] chan_t;
endpackage

// File: rtl/arb_fifo.sv
module arb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt;
  logic            do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/arb_chan_pick.sv
module arb_chan_pick #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] aged,
  input  logic [NPORT-1:0] hi,
  output logic [NPORT-1:0] gnt
);
  localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [PIW-1:0]   ptr, ptr_nxt;
  logic [NPORT-1:0] m_aged, m_hi, m_lo, cand;
  logic             found;
  int               idx;

  assign m_aged = req & aged;
  assign m_hi   = req & hi & ~aged;
  assign m_lo   = req & ~hi & ~aged;
  assign cand   = (|m_aged) ? m_aged : ((|m_hi) ? m_hi : m_lo);

  always_comb begin
    gnt     = '0;
    ptr_nxt = ptr;
    found   = 1'b0;
    idx     = 0;
    for (int k = 0; k < NPORT; k++) begin
      idx = int'(ptr) + k;
      if (idx >= NPORT) idx = idx - NPORT;
      if (!found && en && cand[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        ptr_nxt  = (idx == NPORT - 1) ? '0 : PIW'(idx + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/aging_xbar_arb.sv
module aging_xbar_arb
  import aging_arb_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BLK_BYTES = 64,
  parameter int PQ_DEPTH  = 4,
  parameter int CQ_DEPTH  = 4,
  parameter int AGE_MAX   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         port_hi,
  input  logic [NPORT-1:0]         in_valid,
  output logic [NPORT-1:0]         in_ready,
  input  logic [NPORT*AW-1:0]      in_addr,
  input  logic [NPORT*DW-1:0]      in_data,
  output logic [NCHAN-1:0]         out_valid,
  input  logic [NCHAN-1:0]         out_ready,
  output logic [NCHAN*AW-1:0]      out_addr,
  output logic [NCHAN*DW-1:0]      out_data,
  output logic [NCHAN*$clog2(NPORT)-1:0] out_src
);
  localparam int BOFF = $clog2(BLK_BYTES);
  localparam int PW   = $clog2(NPORT);
  localparam int AGW  = $clog2(AGE_MAX + 1);
  localparam int HW   = AW + DW;
  localparam int EW   = PW + HW;

  logic [HW-1:0]    head   [NPORT];
  logic [NPORT-1:0] head_v, pq_full, port_gnt, aged;
  logic [AGW-1:0]   age    [NPORT];
  logic [NPORT-1:0] req    [NCHAN];
  logic [NPORT-1:0] gnt    [NCHAN];
  logic [NCHAN-1:0] cq_full, cq_empty;

  // Per-port request FIFOs.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic pq_empty;
    arb_fifo #(.W(HW), .DEPTH(PQ_DEPTH)) u_pq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[p]),
      .din   ({in_addr[p*AW +: AW], in_data[p*DW +: DW]}),
      .pop   (port_gnt[p]),
      .dout  (head[p]),
      .empty (pq_empty),
      .full  (pq_full[p])
    );
    assign head_v[p]   = !pq_empty;
    assign in_ready[p] = !pq_full[p];
    assign aged[p]     = !port_hi[p] && head_v[p] && (age[p] == AGW'(AGE_MAX));
  end

  // Age of each low-priority head: counts losing cycles, saturates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) age[p] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (!head_v[p] || port_hi[p] || port_gnt[p]) age[p] <= '0;
        else if (age[p] != AGW'(AGE_MAX))            age[p] <= age[p] + 1'b1;
      end
    end
  end

  // Channel decode from the interleave bits of each head.
  always_comb begin
    for (int c = 0; c < NCHAN; c++) begin
      for (int p = 0; p < NPORT; p++) begin
        req[c][p] = head_v[p] && (head[p][DW+BOFF +: CHW] == chan_t'(c));
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      port_gnt[p] = 1'b0;
      for (int c = 0; c < NCHAN; c++) port_gnt[p] = port_gnt[p] | gnt[c][p];
    end
  end

  // Per-channel arbitration, crossbar select and back-end queue.
  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [EW-1:0] sel, cq_head;

    arb_chan_pick #(.NPORT(NPORT)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!cq_full[c]),
      .req   (req[c]),
      .aged  (aged),
      .hi    (port_hi),
      .gnt   (gnt[c])
    );

    always_comb begin
      sel = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (gnt[c][p]) sel = sel | {PW'(p), head[p]};
      end
    end

    arb_fifo #(.W(EW), .DEPTH(CQ_DEPTH)) u_cq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (|gnt[c]),
      .din   (sel),
      .pop   (out_ready[c]),
      .dout  (cq_head),
      .empty (cq_empty[c]),
      .full  (cq_full[c])
    );

    assign out_valid[c]            = !cq_empty[c];
    assign out_data[c*DW +: DW]    = cq_head[DW-1:0];
    assign out_addr[c*AW +: AW]    = cq_head[DW +: AW];
    assign out_src[c*PW +: PW]     = cq_head[HW +: PW];
  end
endmodule

// File: rtl/aging_xbar_arb_chk.sv
module aging_xbar_arb_chk
  import aging_arb_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BLK_BYTES = 64,
  parameter int AGE_MAX   = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORT-1:0]       port_hi,
  input logic [NPORT-1:0]       head_v,
  input logic [$clog2(AGE_MAX+1)-1:0] age [NPORT],
  input logic [NPORT-1:0]       req [NCHAN],
  input logic [NPORT-1:0]       gnt [NCHAN],
  input logic [NCHAN-1:0]       cq_full,
  input logic [NCHAN-1:0]       out_valid,
  input logic [NCHAN-1:0]       out_ready,
  input logic [NCHAN*AW-1:0]    out_addr,
  input logic [NCHAN*DW-1:0]    out_data,
  input logic [NCHAN*$clog2(NPORT)-1:0] out_src
);
  localparam int BOFF = $clog2(BLK_BYTES);
  localparam int PW   = $clog2(NPORT);
  localparam int AGW  = $clog2(AGE_MAX + 1);

  logic [NPORT-1:0] old;
  always_comb begin
    for (int p = 0; p < NPORT; p++)
      old[p] = !port_hi[p] && head_v[p] && (age[p] == AGW'(AGE_MAX));
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_c
    // R7: at most one winner per channel per cycle
    a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[c]));
    // R7: a full back-end queue takes nothing
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      cq_full[c] |-> (gnt[c] == '0));
    // R3: a channel with room and a requester grants someone
    a_r3_work: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req[c]) && !cq_full[c]) |-> (|gnt[c]));
    // R5: an aged head outranks everyone
    a_r5_aged_first: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(req[c] & old)) && !cq_full[c]) |-> (|(gnt[c] & old)));
    // R4: high beats low when nobody is aged
    a_r4_high_over_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(req[c] & port_hi)) && !(|(req[c] & old)) && !cq_full[c])
        |-> (|(gnt[c] & port_hi)));
    // R1: what leaves a channel belongs to it
    a_r1_route: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[c] |-> (out_addr[c*AW+BOFF +: CHW] == chan_t'(c)));
    // R2: stalled output holds still
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[c] && !out_ready[c]) |=>
        (out_valid[c] && $stable(out_addr[c*AW +: AW]) &&
         $stable(out_data[c*DW +: DW]) && $stable(out_src[c*PW +: PW])));
  end
endmodule

bind aging_xbar_arb aging_xbar_arb_chk #(
  .NPORT(NPORT), .AW(AW), .DW(DW), .BLK_BYTES(BLK_BYTES), .AGE_MAX(AGE_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_hi   (port_hi),
  .head_v    (head_v),
  .age       (age),
  .req       (req),
  .gnt       (gnt),
  .cq_full   (cq_full),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .out_src   (out_src)
);

// File: tb/aging_xbar_arb_tb.sv
`timescale 1ns/1ps
module aging_xbar_arb_tb;
  localparam int NP = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int AGE_MAX = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   port_hi = '0;
  logic [NP-1:0]   in_valid = '0;
  logic [NP-1:0]   in_ready;
  logic [NP*AW-1:0] in_addr = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [3:0]      out_valid;
  logic [3:0]      out_ready = 4'hF;
  logic [4*AW-1:0] out_addr;
  logic [4*DW-1:0] out_data;
  logic [7:0]      out_src;

  int total = 0;
  int bad = 0;

  int          lg_n   [4];
  int          lg_src [4][64];
  logic [15:0] lg_addr[4][64];
  logic [15:0] lg_data[4][64];

  always #2.5 clk = ~clk;

  aging_xbar_arb u_dut (
    .clk(clk), .rst_n(rst_n), .port_hi(port_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_src(out_src)
  );

  initial begin
    for (int c = 0; c < 4; c++) lg_n[c] = 0;
  end

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (rst_n && out_valid[c] && out_ready[c] && lg_n[c] < 64) begin
        lg_src[c][lg_n[c]]  = int'(out_src[c*2 +: 2]);
        lg_addr[c][lg_n[c]] = out_addr[c*AW +: AW];
        lg_data[c][lg_n[c]] = out_data[c*DW +: DW];
        lg_n[c] = lg_n[c] + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_log();
    for (int c = 0; c < 4; c++) lg_n[c] = 0;
  endtask

  function automatic logic [15:0] mk_addr(input int ch, input int hi_bits, input int low);
    return 16'((hi_bits << 8) | (ch << 6) | (low & 63));
  endfunction

  task automatic set_port(input int p, input logic [15:0] a, input logic [15:0] d);
    in_addr[p*AW +: AW] = a;
    in_data[p*DW +: DW] = d;
    in_valid[p] = 1'b1;
  endtask

  task automatic push1(input int p, input logic [15:0] a, input logic [15:0] d);
    set_port(p, a, d);
    forever begin
      @(negedge clk);
      if (in_ready[p]) break;
    end
    tick();
    in_valid[p] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 out_valid after reset", int'(out_valid), 0);
    chk("R8 in_ready after reset", int'(in_ready), 15);
  endtask

  task automatic t_route();
    clear_log();
    port_hi = '0;
    for (int c = 0; c < 4; c++) push1(3, mk_addr(c, c + 1, 5 + c), 16'(16'h3000 + c));
    repeat (6) tick();
    for (int c = 0; c < 4; c++) begin
      chk("R1 count per channel", lg_n[c], 1);
      chk("R1 address kept", int'(lg_addr[c][0]), int'(mk_addr(c, c + 1, 5 + c)));
      chk("R1 data kept", int'(lg_data[c][0]), 16'h3000 + c);
      chk("R1 source port", lg_src[c][0], 3);
    end
  endtask

  task automatic t_parallel();
    clear_log();
    out_ready = 4'h0;
    for (int p = 0; p < 4; p++) set_port(p, mk_addr((p + 1) % 4, 0, 0), 16'(16'h4000 + p));
    tick();
    in_valid = '0;
    tick();
    @(negedge clk);
    chk("R3 all channels valid one cycle after grant", int'(out_valid), 15);
    for (int c = 0; c < 4; c++)
      chk("R3 source on channel", int'(out_src[c*2 +: 2]), (c + 3) % 4);
    tick();
    out_ready = 4'hF;
    repeat (3) tick();
  endtask

  task automatic t_prio();
    clear_log();
    port_hi = 4'b0010;
    set_port(0, mk_addr(1, 0, 0), 16'h5000);
    set_port(1, mk_addr(1, 0, 0), 16'h5001);
    tick();
    in_valid = '0;
    repeat (5) tick();
    chk("R4 two outputs", lg_n[1], 2);
    chk("R4 high port first", lg_src[1][0], 1);
    chk("R4 low port second", lg_src[1][1], 0);
  endtask

  task automatic t_rr();
    int m;
    clear_log();
    port_hi = 4'hF;
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 4; p++) set_port(p, mk_addr(2, k, p), 16'(16'h6000 + p * 16 + k));
      tick();
    end
    in_valid = '0;
    repeat (12) tick();
    chk("R6 eight outputs", lg_n[2], 8);
    for (int w = 0; w < 2; w++) begin
      m = 0;
      for (int i = 0; i < 4; i++) m = m | (1 << lg_src[2][w * 4 + i]);
      chk("R6 every port once per window", m, 15);
    end
    for (int p = 0; p < 4; p++) begin
      int first = -1;
      int second = -1;
      for (int i = 0; i < 8; i++) begin
        if (lg_src[2][i] == p) begin
          if (first < 0) first = int'(lg_data[2][i]);
          else second = int'(lg_data[2][i]);
        end
      end
      chk("R2 per-port order", second - first, 1);
    end
  endtask

  task automatic t_age();
    int cnt0;
    clear_log();
    port_hi = 4'b0110;
    set_port(0, mk_addr(0, 1, 0), 16'h7000);
    set_port(1, mk_addr(0, 2, 0), 16'h7100);
    set_port(2, mk_addr(0, 3, 0), 16'h7200);
    tick();
    set_port(0, mk_addr(0, 1, 1), 16'h7001);
    tick();
    in_valid[0] = 1'b0;
    repeat (20) tick();
    in_valid = '0;
    repeat (15) tick();
    chk("R5 first aged grant position", lg_src[0][AGE_MAX], 0);
    chk("R5 first aged grant data", int'(lg_data[0][AGE_MAX]), 16'h7000);
    chk("R5 second grant after age reset", lg_src[0][2 * AGE_MAX + 1], 0);
    cnt0 = 0;
    for (int i = 0; i < 2 * AGE_MAX + 2; i++) if (lg_src[0][i] == 0) cnt0++;
    chk("R5 low port grants in window", cnt0, 2);
  endtask

  task automatic t_bp();
    int acc;
    logic take;
    clear_log();
    port_hi = '0;
    out_ready = 4'b1011;
    acc = 0;
    for (int k = 0; k < 12; k++) begin
      set_port(0, mk_addr(2, 0, 0), 16'(acc));
      @(negedge clk);
      take = in_ready[0];
      tick();
      if (take) acc++;
    end
    in_valid[0] = 1'b0;
    chk("R2 beats taken while channel stalled", acc, 8);
    @(negedge clk);
    chk("R2 in_ready low with FIFO full", int'(in_ready[0]), 0);
    chk("R2 stalled output valid", int'(out_valid[2]), 1);
    chk("R2 stalled output holds first beat", int'(out_data[2*DW +: DW]), 0);
    tick();
    push1(1, mk_addr(3, 0, 0), 16'hBEEF);
    repeat (3) tick();
    chk("R7 other channel flows during stall", lg_n[3], 1);
    chk("R7 other channel data", int'(lg_data[3][0]), 16'hBEEF);
    chk("R7 nothing left stalled channel", lg_n[2], 0);
    out_ready = 4'hF;
    repeat (14) tick();
    chk("R2 drained count", lg_n[2], 8);
    for (int i = 0; i < 8; i++) chk("R2 drain order", int'(lg_data[2][i]), i);
  endtask

  initial begin
    #(100000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    tick();
    t_route();
    t_parallel();
    t_prio();
    t_rr();
    t_age();
    t_bp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule